// File: doc/BRIEF.md
# Dual-channel analog port host interface

This block sits between a microprocessor bus and a two-channel analog I/O core. The host drives an active-low select, active-low write and read strobes, a target line that picks the converter side (ADC or DAC) and a channel line that picks channel A or B. Byte data travels over a bidirectional 8-bit port, which is split here into an input byte, an output byte and an output enable. The port drives only while the host reads.

A write addressed to the DAC side fills one of two DAC holding registers. A write addressed to the ADC side asks the external successive-approximation engine for a conversion on the addressed channel. The request is a one-cycle start pulse. The engine answers with a done pulse and a result byte. The result goes into an output latch and an active-low completion flag falls. If the read strobe is also low during a DAC write, the DAC register takes the ADC output latch instead of the host byte, so the result moves to the DAC without passing through the host.

All strobes are sampled on the system clock and are assumed to be synchronous to it already. The action of a write happens at the clock edge that first sees the write strobe high again after a selected write access. This models a conversion starting on the rising edge of the write strobe.

Top module: `aio_host_port`

## Requirements
- R1: After reset both DAC registers read 0, the ADC output latch is 0, `done_n` is 1 and `conv_start` is 0.
- R2: A strobe given while `cs_n` is high has no effect: no DAC register changes, no start pulse is issued and the data port is not driven.
- R3: A write with `tgt` = 0 (ADC) gives exactly one cycle of `conv_start`, with `conv_chan` equal to the addressed `ch`. The pulse is visible in the cycle after the clock edge that sees `wr_n` high following the selected write.
- R4: A write with `tgt` = 1 (DAC) and `rd_n` high loads `data_i` into the register of channel `ch`, where 0 is A (`dac_flat[7:0]`) and 1 is B (`dac_flat[15:8]`). The update is visible with the same timing as R3, and the other register is unchanged.
- R5: A DAC write during which `rd_n` is also low loads the ADC output latch into the addressed DAC register and ignores `data_i`.
- R6: `data_oe` is 1 exactly while `cs_n` and `rd_n` are both low, and `data_o` then carries the ADC output latch. With `rd_n` high the port is never driven, including during a whole conversion.
- R7: A `conv_done` pulse while a conversion is pending loads `conv_result` into the latch, and `done_n` goes low in the next cycle. A `conv_done` with no conversion pending changes neither the latch nor `done_n`.
- R8: `done_n` returns high one cycle after a read access with `tgt` = 0 begins, or together with a new start pulse.
- R9: If `cs_n` and `rd_n` stay low through a conversion, the port shows the previous result until the cycle in which `done_n` falls, and shows the new result from that cycle on.
- R10: If a completion and a new conversion start fall on the same clock edge, the arriving result is latched, `done_n` stays high and the new conversion stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| tgt | input | 1 | Target side: 0 ADC, 1 DAC |
| ch | input | 1 | Channel: 0 A, 1 B |
| data_i | input | 8 | Byte written by the host |
| data_o | output | 8 | Byte presented to the host (ADC output latch) |
| data_oe | output | 1 | Port drive enable; high impedance when 0 |
| done_n | output | 1 | Active-low conversion-complete flag |
| conv_start | output | 1 | One-cycle start request to the conversion engine |
| conv_chan | output | 1 | Channel of the requested conversion |
| conv_done | input | 1 | Completion pulse from the conversion engine |
| conv_result | input | 8 | Result byte from the conversion engine |
| dac_flat | output | 16 | DAC registers, channel A in the low byte |

## Verification
The completion of one conversion and the start of the next can land on the same clock edge. The bench provokes this by raising `conv_done` in the same cycle in which the write strobe returns high after an ADC write. It then expects a start pulse, a completion flag that stays high, and the arriving byte on the port at the following read. A second case covers a DAC write that takes the latch in the same cycle a result arrives. Here the DAC must receive the latch contents from before that edge.

// File: rtl/aio_pkg.sv
package aio_pkg;

    typedef enum logic {
        TGT_ADC = 1'b0,
        TGT_DAC = 1'b1
    } target_e;

endpackage

// File: rtl/aio_wr_capture.sv
module aio_wr_capture
    import aio_pkg::*;
#(
    parameter int DW  = 8,
    parameter int CHW = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_n,
    input  logic           wr_n,
    input  logic           rd_n,
    input  logic           tgt,
    input  logic [CHW-1:0] ch,
    input  logic [DW-1:0]  data_i,
    output logic           fire,
    output target_e        fire_tgt,
    output logic [CHW-1:0] fire_ch,
    output logic [DW-1:0]  fire_data,
    output logic           fire_rd
);

    typedef struct packed {
        logic           act;
        target_e        tgt;
        logic [CHW-1:0] ch;
        logic [DW-1:0]  data;
        logic           rd;
    } cap_t;

    cap_t cap_d, cap_q;
    logic wr_access;

    always_comb begin
        wr_access = !cs_n && !wr_n;
        cap_d     = cap_q;
        cap_d.act = wr_access;
        if (wr_access) begin
            cap_d.tgt  = target_e'(tgt);
            cap_d.ch   = ch;
            cap_d.data = data_i;
            cap_d.rd   = !rd_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    // The action happens at the edge that first sees the strobe released.
    assign fire      = cap_q.act && wr_n;
    assign fire_tgt  = cap_q.tgt;
    assign fire_ch   = cap_q.ch;
    assign fire_data = cap_q.data;
    assign fire_rd   = cap_q.rd;

endmodule

// File: rtl/aio_conv_ctrl.sv
module aio_conv_ctrl #(
    parameter int DW  = 8,
    parameter int CHW = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_req,
    input  logic [CHW-1:0] start_ch,
    input  logic           read_clear,
    input  logic           conv_done,
    input  logic [DW-1:0]  conv_result,
    output logic           conv_start,
    output logic [CHW-1:0] conv_chan,
    output logic [DW-1:0]  latch,
    output logic           done_n
);

    typedef struct packed {
        logic           start;
        logic [CHW-1:0] chan;
        logic           busy;
        logic [DW-1:0]  latch;
        logic           done_n;
    } conv_t;

    conv_t cv_d, cv_q;

    always_comb begin
        cv_d       = cv_q;
        cv_d.start = 1'b0;
        if (read_clear) begin
            cv_d.done_n = 1'b1;
        end
        if (conv_done && cv_q.busy) begin
            cv_d.latch  = conv_result;
            cv_d.busy   = 1'b0;
            cv_d.done_n = 1'b0;
        end
        // A new start overrides a completion seen on the same edge.
        if (start_req) begin
            cv_d.start  = 1'b1;
            cv_d.chan   = start_ch;
            cv_d.busy   = 1'b1;
            cv_d.done_n = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cv_q        <= '0;
            cv_q.done_n <= 1'b1;
        end else begin
            cv_q <= cv_d;
        end
    end

    assign conv_start = cv_q.start;
    assign conv_chan  = cv_q.chan;
    assign latch      = cv_q.latch;
    assign done_n     = cv_q.done_n;

endmodule

// File: rtl/aio_dac_bank.sv
module aio_dac_bank #(
    parameter int DW  = 8,
    parameter int NCH = 2,
    parameter int CHW = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CHW-1:0]    wr_ch,
    input  logic [DW-1:0]     wr_val,
    output logic [NCH*DW-1:0] dac_flat
);

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic [DW-1:0] reg_d, reg_q;

        always_comb begin
            reg_d = reg_q;
            if (wr_en && (wr_ch == CHW'(g))) begin
                reg_d = wr_val;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                reg_q <= '0;
            end else begin
                reg_q <= reg_d;
            end
        end

        assign dac_flat[g*DW +: DW] = reg_q;
    end

endmodule

// File: rtl/aio_host_port.sv
module aio_host_port
    import aio_pkg::*;
#(
    parameter int DW  = 8,
    parameter int NCH = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cs_n,
    input  logic                                wr_n,
    input  logic                                rd_n,
    input  logic                                tgt,
    input  logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] ch,
    input  logic [DW-1:0]                       data_i,
    output logic [DW-1:0]                       data_o,
    output logic                                data_oe,
    output logic                                done_n,
    output logic                                conv_start,
    output logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] conv_chan,
    input  logic                                conv_done,
    input  logic [DW-1:0]                       conv_result,
    output logic [NCH*DW-1:0]                   dac_flat
);

    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        logic rd_prev;
    } top_t;

    top_t top_d, top_q;

    logic           fire;
    target_e        fire_tgt;
    logic [CHW-1:0] fire_ch;
    logic [DW-1:0]  fire_data;
    logic           fire_rd;
    logic [DW-1:0]  latch;
    logic           rd_access;
    logic           start_req;
    logic           read_clear;
    logic           dac_wr;
    logic [DW-1:0]  dac_val;

    aio_wr_capture #(.DW(DW), .CHW(CHW)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .rd_n      (rd_n),
        .tgt       (tgt),
        .ch        (ch),
        .data_i    (data_i),
        .fire      (fire),
        .fire_tgt  (fire_tgt),
        .fire_ch   (fire_ch),
        .fire_data (fire_data),
        .fire_rd   (fire_rd)
    );

    always_comb begin
        rd_access     = !cs_n && !rd_n;
        top_d         = top_q;
        top_d.rd_prev = rd_access;
        read_clear    = rd_access && !top_q.rd_prev && (target_e'(tgt) == TGT_ADC);
        start_req     = fire && (fire_tgt == TGT_ADC);
        dac_wr        = fire && (fire_tgt == TGT_DAC);
        dac_val       = fire_rd ? latch : fire_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    aio_conv_ctrl #(.DW(DW), .CHW(CHW)) u_conv (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req   (start_req),
        .start_ch    (fire_ch),
        .read_clear  (read_clear),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .conv_start  (conv_start),
        .conv_chan   (conv_chan),
        .latch       (latch),
        .done_n      (done_n)
    );

    aio_dac_bank #(.DW(DW), .NCH(NCH), .CHW(CHW)) u_dac (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (dac_wr),
        .wr_ch    (fire_ch),
        .wr_val   (dac_val),
        .dac_flat (dac_flat)
    );

    assign data_oe = rd_access;
    assign data_o  = latch;

endmodule

// File: rtl/aio_host_port_chk.sv
module aio_host_port_chk #(
    parameter int DW  = 8,
    parameter int NCH = 2
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                cs_n,
    input logic                                wr_n,
    input logic                                rd_n,
    input logic                                tgt,
    input logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] ch,
    input logic [DW-1:0]                       data_i,
    input logic [DW-1:0]                       data_o,
    input logic                                data_oe,
    input logic                                done_n,
    input logic                                conv_start,
    input logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] conv_chan,
    input logic                                conv_done,
    input logic [DW-1:0]                       conv_result,
    input logic [NCH*DW-1:0]                   dac_flat
);

    a_r2_no_action_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |=> ($stable(dac_flat) && !conv_start));

    a_r6_float_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |-> !data_oe);

    a_r3_start_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    a_r8_start_raises_flag: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> done_n);

    a_r7_flag_falls_on_result: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_n) |-> $past(conv_done));

    a_r9_result_held_while_flag_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_n && $past(!done_n)) |-> $stable(data_o));

endmodule

bind aio_host_port aio_host_port_chk #(.DW(DW), .NCH(NCH)) u_chk (.*);

// File: tb/test_aio_host_port.sv
module test_aio_host_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, tgt = 1'b0;
    logic [0:0]  ch = '0;
    logic [7:0]  data_i = '0;
    logic [7:0]  data_o;
    logic        data_oe, done_n, conv_start;
    logic [0:0]  conv_chan;
    logic        conv_done = 1'b0;
    logic [7:0]  conv_result = '0;
    logic [15:0] dac_flat;

    int n_chk = 0, n_bad = 0;
    logic [7:0] exp_dac [2];
    logic [7:0] exp_latch;

    always #2 clk = ~clk;

    aio_host_port i_aio_host_port (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Selected write; optional read held low and optional completion on the firing edge.
    task automatic bus_write(input logic t, input logic c, input logic [7:0] d,
                             input logic with_rd, input logic fire_done, input logic [7:0] res);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; tgt = t; ch = c; data_i = d; rd_n = !with_rd;
        @(negedge clk);
        wr_n = 1'b1;
        if (fire_done) begin conv_done = 1'b1; conv_result = res; end
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1; conv_done = 1'b0;
    endtask

    task automatic finish_conv(input logic [7:0] res);
        @(negedge clk);
        conv_done = 1'b1; conv_result = res;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic read_adc(input logic [7:0] exp, input string req);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; tgt = 1'b0;
        #1;
        chk({req, " oe"}, int'(data_oe), 1);
        chk({req, " data"}, int'(data_o), int'(exp));
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
        chk({req, " R8 flag cleared by read"}, int'(done_n), 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        exp_dac[0] = 8'h00; exp_dac[1] = 8'h00; exp_latch = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 dac", int'(dac_flat), 0);
        chk("R1 done_n", int'(done_n), 1);
        chk("R1 start", int'(conv_start), 0);
        read_adc(8'h00, "R1 latch");

        // R4 exhaustive DAC sweep on both channels
        for (int v = 0; v < 256; v++) begin
            for (int c = 0; c < 2; c++) begin
                logic [7:0] val;
                val = 8'(v ^ (c * 8'h5A));
                bus_write(1'b1, c[0], val, 1'b0, 1'b0, 8'h00);
                exp_dac[c] = val;
                chk("R4 dac load", int'(dac_flat), int'({exp_dac[1], exp_dac[0]}));
                chk("R4 no start", int'(conv_start), 0);
            end
        end

        // R2 deselected strobes
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; tgt = 1'b1; ch = 1'b0; data_i = 8'hC3; rd_n = 1'b0;
        #1 chk("R2 no drive", int'(data_oe), 0);
        @(negedge clk);
        wr_n = 1'b1; tgt = 1'b0;
        @(negedge clk);
        rd_n = 1'b1;
        chk("R2 dac unchanged", int'(dac_flat), int'({exp_dac[1], exp_dac[0]}));
        chk("R2 no start", int'(conv_start), 0);

        // R3 R7 R8 conversions on both channels
        for (int i = 0; i < 16; i++) begin
            logic [7:0] res;
            res = 8'(i * 17 + 3);
            bus_write(1'b0, i[0], 8'h00, 1'b0, 1'b0, 8'h00);
            chk("R3 start pulse", int'(conv_start), 1);
            chk("R3 chan", int'(conv_chan), i & 1);
            chk("R8 flag high at start", int'(done_n), 1);
            chk("R6 no drive during conversion", int'(data_oe), 0);
            @(negedge clk);
            chk("R3 pulse ends", int'(conv_start), 0);
            finish_conv(res);
            exp_latch = res;
            chk("R7 flag low", int'(done_n), 0);
            read_adc(exp_latch, "R7 result");
        end

        // R7 stray completion ignored
        finish_conv(8'hEE);
        chk("R7 stray flag", int'(done_n), 1);
        read_adc(exp_latch, "R7 stray latch");

        // R8 new start clears a low flag
        bus_write(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
        finish_conv(8'h44);
        exp_latch = 8'h44;
        chk("R7 flag low", int'(done_n), 0);
        bus_write(1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00);
        chk("R8 start raises flag", int'(done_n), 1);

        // R10 completion and start on the same edge
        bus_write(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h6B);
        exp_latch = 8'h6B;
        chk("R10 start", int'(conv_start), 1);
        chk("R10 flag high", int'(done_n), 1);
        read_adc(exp_latch, "R10 latched");
        finish_conv(8'h91);
        exp_latch = 8'h91;
        chk("R10 still pending", int'(done_n), 0);

        // R5 direct latch to DAC, both channels
        bus_write(1'b1, 1'b0, 8'h12, 1'b1, 1'b0, 8'h00);
        exp_dac[0] = exp_latch;
        chk("R5 dac A from latch", int'(dac_flat), int'({exp_dac[1], exp_dac[0]}));
        bus_write(1'b1, 1'b1, 8'h34, 1'b1, 1'b0, 8'h00);
        exp_dac[1] = exp_latch;
        chk("R5 dac B from latch", int'(dac_flat), int'({exp_dac[1], exp_dac[0]}));

        // R9 read held through a conversion
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; tgt = 1'b0; ch = 1'b1;
        @(negedge clk);
        wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        chk("R9 start", int'(conv_start), 1);
        chk("R9 old data", int'(data_o), int'(exp_latch));
        chk("R6 held oe", int'(data_oe), 1);
        conv_done = 1'b1; conv_result = 8'h27;
        #1 chk("R9 old data before edge", int'(data_o), int'(exp_latch));
        @(negedge clk);
        conv_done = 1'b0;
        exp_latch = 8'h27;
        chk("R9 flag low", int'(done_n), 0);
        chk("R9 new data", int'(data_o), int'(exp_latch));
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
        #1 chk("R6 release", int'(data_oe), 0);

        // Result arrival and latch-to-DAC write on one edge: DAC gets old latch (R5)
        bus_write(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
        bus_write(1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 8'hB8);
        exp_dac[0] = exp_latch;
        exp_latch = 8'hB8;
        chk("R5 old latch on shared edge", int'(dac_flat), int'({exp_dac[1], exp_dac[0]}));
        chk("R7 flag low shared edge", int'(done_n), 0);
        read_adc(exp_latch, "R7 shared edge latch");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule